// File: doc/BRIEF.md
# Receive Ring Frame Writer

This block takes received Ethernet frames as a byte stream and stores them in a circular receive region of a 32 KB local buffer RAM. It writes through a single 16-bit word port. Each stored frame starts with a four-word header, followed by its data packed two bytes per word. The header holds an event word, a status word, the byte address where the next frame will start, and the data byte count. The other three header words and the data are written first. The event word 0x0008 is written last, so a host polling the frame start never sees a half-written frame.

The ring spans from `lowerPage`×256 up to and including the word at `upperPage`×256+0xFE. Every write address, header words included, wraps from that top word back to the bottom. The host owns a stop pointer and raises it as it consumes frames. The writer never writes the word that contains the stop pointer. A frame that would need that word is abandoned and counted as an overflow, and the next frame reuses the same start. When discard is enabled, a frame flagged as errored on its last byte is abandoned the same way, but it is not counted.

After a frame's last byte, the stream must stay idle for at least five cycles while the header is back-filled. The limits may only change while reset is asserted.

Top module: `rxring_writer`

## Requirements
- R1: During reset and right after it, no write occurs and `ovfCount` is 0; the first frame after reset starts at byte address `lowerPage`×256.
- R2: A frame stored at word address S has status at S+1, the next-frame byte address at S+2, the byte count (low 14 bits) at S+3, and data from S+4; the first byte of each pair is in bits 7:0 and the second in bits 15:8.
- R3: The event word 0x0008 is written at S, and it is the last write made for that frame.
- R4: The status word is 0x2000 for a frame without error and 0x0001 for an errored frame that is kept (discard off).
- R5: For an odd-length frame, the final byte sits in bits 7:0 of its word with bits 15:8 zero; the next frame starts at the following word.
- R6: Every write address, header or data, that steps past the word at `upperPage`×256+0xFE continues at `lowerPage`×256, and no write falls outside the ring.
- R7: No write is ever made to the word containing `stopPtr`.
- R8: A frame that would need the stop word, for its header or its data, gets no event word; `ovfCount` increments by exactly one; the next frame starts at the same address.
- R9: With `discardBad` high, a frame whose last byte carries `inErr` gets no header; `ovfCount` is unchanged; the next frame starts at the same address.
- R10: After a kept frame, the word at the next frame's start is written 0x0000 before the event word, unless that word is the stop word.
- R11: After an overflow, the remaining bytes of that frame, up to its last byte, cause no writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| inValid | input | 1 | A frame byte is present |
| inData | input | 8 | Frame byte |
| inLast | input | 1 | This byte ends the frame |
| inErr | input | 1 | Frame is errored; sampled with the last byte |
| discardBad | input | 1 | Drop errored frames instead of storing them |
| lowerPage | input | 7 | Bottom of the ring, in 256-byte pages |
| upperPage | input | 7 | Top page of the ring |
| stopPtr | input | 15 | Host stop byte address; its word is never written |
| memWe | output | 1 | RAM word write enable |
| memAddr | output | 15 | RAM byte address, always even |
| memData | output | 16 | RAM write data |
| ovfCount | output | 16 | Count of frames dropped for lack of space |

## Verification
Two events can land on the same data word: the wrap from the top word back to the bottom, and the stop-pointer collision that ends a frame. This happens when the host has left the stop pointer on the top word of a one-page ring. The bench provokes it by sending full-sized frames without consuming them, so the third frame reaches the top word. It then checks that the frame is dropped and counted, that nothing is written at the top word or past the wrap, and that once the stop pointer is raised the same frame header begins again at the same address and its data wraps correctly. A random phase with a fixed seed mixes lengths, errors, discard settings and host consumption. After every frame, the whole ring is compared against a model RAM.

// File: rtl/rxring_pkg.sv
package rxring_pkg;

  typedef enum logic [2:0] {
    HDR_STAT, HDR_NEXT, HDR_CNT, HDR_CLR, HDR_EVT
  } hdrSel_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RECV, ST_DROP, ST_STAT, ST_NEXT, ST_CNT, ST_CLR, ST_EVT
  } wrState_e;

  // Strobes from the sequencer to the datapath, valid for one cycle.
  typedef struct packed {
    logic    startFrame;
    logic    takeByte;
    logic    storeLow;
    logic    writeWord;
    logic    overflow;
    logic    hdrWrite;
    hdrSel_e hdrSel;
  } strobes_t;

  localparam logic [15:0] EVENT_DONE = 16'h0008;
  localparam logic [15:0] STAT_GOOD  = 16'h2000;
  localparam logic [15:0] STAT_BAD   = 16'h0001;

endpackage

// File: rtl/rxring_ctrl.sv
module rxring_ctrl
  import rxring_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     inValid,
  input  logic     inLast,
  input  logic     inErr,
  input  logic     discardBad,
  input  logic     hdrHit,
  input  logic     hitStopNew,
  input  logic     hitStopCur,
  input  logic     hasLow,
  input  logic     clrBlocked,
  output strobes_t strobe
);

  wrState_e state, nextState;
  logic     wordReady, hitStop;

  always_comb begin
    strobe    = '0;
    nextState = state;
    wordReady = 1'b0;
    hitStop   = 1'b0;
    case (state)
      ST_IDLE, ST_RECV: begin
        if (inValid) begin
          if (state == ST_IDLE && hdrHit) begin
            strobe.overflow = 1'b1;
            nextState = inLast ? ST_IDLE : ST_DROP;
          end else begin
            strobe.startFrame = (state == ST_IDLE);
            wordReady = inLast || (state == ST_RECV && hasLow);
            hitStop   = (state == ST_IDLE) ? hitStopNew : hitStopCur;
            if (wordReady && hitStop) begin
              strobe.overflow = 1'b1;
              nextState = inLast ? ST_IDLE : ST_DROP;
            end else if (wordReady) begin
              strobe.takeByte  = 1'b1;
              strobe.writeWord = 1'b1;
              if (inLast) nextState = (inErr && discardBad) ? ST_IDLE : ST_STAT;
              else        nextState = ST_RECV;
            end else begin
              strobe.takeByte = 1'b1;
              strobe.storeLow = 1'b1;
              nextState = ST_RECV;
            end
          end
        end
      end
      ST_DROP: if (inValid && inLast) nextState = ST_IDLE;
      ST_STAT: begin
        strobe.hdrWrite = 1'b1; strobe.hdrSel = HDR_STAT; nextState = ST_NEXT;
      end
      ST_NEXT: begin
        strobe.hdrWrite = 1'b1; strobe.hdrSel = HDR_NEXT; nextState = ST_CNT;
      end
      ST_CNT: begin
        strobe.hdrWrite = 1'b1; strobe.hdrSel = HDR_CNT; nextState = ST_CLR;
      end
      ST_CLR: begin
        strobe.hdrWrite = !clrBlocked; strobe.hdrSel = HDR_CLR; nextState = ST_EVT;
      end
      ST_EVT: begin
        strobe.hdrWrite = 1'b1; strobe.hdrSel = HDR_EVT; nextState = ST_IDLE;
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

endmodule

// File: rtl/rxring_dp.sv
module rxring_dp
  import rxring_pkg::*;
#(
  parameter int ADDR_W     = 15,
  parameter int PAGE_SHIFT = 8,
  parameter int CNT_W      = 14,
  parameter int OVF_W      = 16
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic [7:0]                   inData,
  input  logic                         inErr,
  input  logic [ADDR_W-PAGE_SHIFT-1:0] lowerPage,
  input  logic [ADDR_W-PAGE_SHIFT-1:0] upperPage,
  input  logic [ADDR_W-1:0]            stopPtr,
  input  strobes_t                     strobe,
  output logic                         hdrHit,
  output logic                         hitStopNew,
  output logic                         hitStopCur,
  output logic                         hasLow,
  output logic                         clrBlocked,
  output logic                         memWe,
  output logic [ADDR_W-1:0]            memAddr,
  output logic [15:0]                  memData,
  output logic [OVF_W-1:0]             ovfCount
);

  localparam int WORD_W = ADDR_W - 1;
  localparam int OFF_W  = PAGE_SHIFT - 1;

  logic [WORD_W-1:0] loW, topW, stopW;
  logic [WORD_W-1:0] frameStart, dataPtr, effPtr;
  logic [WORD_W-1:0] hdr1, hdr2, hdr3, dataStart;
  logic [7:0]        lowByte;
  logic [CNT_W-1:0]  byteCount;
  logic              errLatch;

  function automatic logic [WORD_W-1:0] stepW(input logic [WORD_W-1:0] p,
                                               input logic [WORD_W-1:0] lo,
                                               input logic [WORD_W-1:0] top);
    return (p == top) ? lo : p + 1'b1;
  endfunction

  assign loW   = {lowerPage, {OFF_W{1'b0}}};
  assign topW  = {upperPage, {OFF_W{1'b1}}};
  assign stopW = stopPtr[ADDR_W-1:1];

  assign hdr1      = stepW(frameStart, loW, topW);
  assign hdr2      = stepW(hdr1, loW, topW);
  assign hdr3      = stepW(hdr2, loW, topW);
  assign dataStart = stepW(hdr3, loW, topW);

  assign hdrHit     = (frameStart == stopW) || (hdr1 == stopW) ||
                      (hdr2 == stopW) || (hdr3 == stopW);
  assign hitStopNew = (dataStart == stopW);
  assign hitStopCur = (dataPtr == stopW);
  assign clrBlocked = (dataPtr == stopW);
  assign effPtr     = strobe.startFrame ? dataStart : dataPtr;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      frameStart <= loW;
      dataPtr    <= loW;
      lowByte    <= '0;
      hasLow     <= 1'b0;
      byteCount  <= '0;
      errLatch   <= 1'b0;
      memWe      <= 1'b0;
      memAddr    <= '0;
      memData    <= '0;
      ovfCount   <= '0;
    end else begin
      memWe <= 1'b0;
      if (strobe.overflow) ovfCount <= ovfCount + 1'b1;
      if (strobe.takeByte) begin
        byteCount <= (strobe.startFrame ? '0 : byteCount) + 1'b1;
        errLatch  <= inErr;
      end
      if (strobe.storeLow) begin
        lowByte <= inData;
        hasLow  <= 1'b1;
        dataPtr <= effPtr;
      end
      if (strobe.writeWord) begin
        memWe   <= 1'b1;
        memAddr <= {effPtr, 1'b0};
        memData <= (!strobe.startFrame && hasLow) ? {inData, lowByte} : {8'h00, inData};
        dataPtr <= stepW(effPtr, loW, topW);
        hasLow  <= 1'b0;
      end
      if (strobe.hdrWrite) begin
        memWe <= 1'b1;
        case (strobe.hdrSel)
          HDR_STAT: begin
            memAddr <= {hdr1, 1'b0};
            memData <= errLatch ? STAT_BAD : STAT_GOOD;
          end
          HDR_NEXT: begin
            memAddr <= {hdr2, 1'b0};
            memData <= 16'({dataPtr, 1'b0});
          end
          HDR_CNT: begin
            memAddr <= {hdr3, 1'b0};
            memData <= 16'(byteCount);
          end
          HDR_CLR: begin
            memAddr <= {dataPtr, 1'b0};
            memData <= 16'h0000;
          end
          default: begin
            memAddr    <= {frameStart, 1'b0};
            memData    <= EVENT_DONE;
            frameStart <= dataPtr;
          end
        endcase
      end
    end
  end

endmodule

// File: rtl/rxring_writer.sv
module rxring_writer
  import rxring_pkg::*;
#(
  parameter int ADDR_W     = 15,
  parameter int PAGE_SHIFT = 8,
  parameter int CNT_W      = 14,
  parameter int OVF_W      = 16
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         inValid,
  input  logic [7:0]                   inData,
  input  logic                         inLast,
  input  logic                         inErr,
  input  logic                         discardBad,
  input  logic [ADDR_W-PAGE_SHIFT-1:0] lowerPage,
  input  logic [ADDR_W-PAGE_SHIFT-1:0] upperPage,
  input  logic [ADDR_W-1:0]            stopPtr,
  output logic                         memWe,
  output logic [ADDR_W-1:0]            memAddr,
  output logic [15:0]                  memData,
  output logic [OVF_W-1:0]             ovfCount
);

  strobes_t strobe;
  logic     hdrHit, hitStopNew, hitStopCur, hasLow, clrBlocked;

  rxring_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inLast(inLast), .inErr(inErr),
    .discardBad(discardBad), .hdrHit(hdrHit), .hitStopNew(hitStopNew),
    .hitStopCur(hitStopCur), .hasLow(hasLow), .clrBlocked(clrBlocked),
    .strobe(strobe)
  );

  rxring_dp #(
    .ADDR_W(ADDR_W), .PAGE_SHIFT(PAGE_SHIFT), .CNT_W(CNT_W), .OVF_W(OVF_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .inData(inData), .inErr(inErr),
    .lowerPage(lowerPage), .upperPage(upperPage), .stopPtr(stopPtr),
    .strobe(strobe), .hdrHit(hdrHit), .hitStopNew(hitStopNew),
    .hitStopCur(hitStopCur), .hasLow(hasLow), .clrBlocked(clrBlocked),
    .memWe(memWe), .memAddr(memAddr), .memData(memData), .ovfCount(ovfCount)
  );

endmodule

// File: rtl/rxring_checks.sv
module rxring_checks #(
  parameter int ADDR_W     = 15,
  parameter int PAGE_SHIFT = 8,
  parameter int OVF_W      = 16
) (
  input logic                         clk,
  input logic                         rstN,
  input logic                         inValid,
  input logic [ADDR_W-PAGE_SHIFT-1:0] lowerPage,
  input logic [ADDR_W-PAGE_SHIFT-1:0] upperPage,
  input logic [ADDR_W-1:0]            stopPtr,
  input logic                         memWe,
  input logic [ADDR_W-1:0]            memAddr,
  input logic [OVF_W-1:0]             ovfCount
);

  localparam int WORD_W = ADDR_W - 1;
  localparam int OFF_W  = PAGE_SHIFT - 1;

  logic [WORD_W-1:0] ringLo, ringTop, wrWord;
  assign ringLo  = {lowerPage, {OFF_W{1'b0}}};
  assign ringTop = {upperPage, {OFF_W{1'b1}}};
  assign wrWord  = memAddr[ADDR_W-1:1];

  assert_write_in_ring_R6: assert property (@(posedge clk) disable iff (!rstN)
    memWe |-> (wrWord >= ringLo && wrWord <= ringTop));

  assert_no_stop_write_R7: assert property (@(posedge clk) disable iff (!rstN)
    memWe |-> (wrWord != $past(stopPtr[ADDR_W-1:1])));

  assert_ovf_single_step_R8: assert property (@(posedge clk) disable iff (!rstN)
    (ovfCount == $past(ovfCount)) || (ovfCount == $past(ovfCount) + 1'b1));

  assert_ovf_needs_byte_R8: assert property (@(posedge clk) disable iff (!rstN)
    !$past(inValid) |-> $stable(ovfCount));

endmodule

bind rxring_writer rxring_checks #(
  .ADDR_W(ADDR_W), .PAGE_SHIFT(PAGE_SHIFT), .OVF_W(OVF_W)
) u_checks (
  .clk(clk), .rstN(rstN), .inValid(inValid), .lowerPage(lowerPage),
  .upperPage(upperPage), .stopPtr(stopPtr), .memWe(memWe),
  .memAddr(memAddr), .ovfCount(ovfCount)
);

// File: tb/rxring_writer_bench.sv
module rxring_writer_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0, inLast = 1'b0, inErr = 1'b0, discardBad = 1'b0;
  logic [7:0]  inData = '0;
  logic [6:0]  lowerPage = 7'd1, upperPage = 7'd3;
  logic [14:0] stopPtr = 15'h03FE;
  logic        memWe;
  logic [14:0] memAddr;
  logic [15:0] memData;
  logic [15:0] ovfCount;

  int checks = 0, errors = 0;
  logic [15:0] ram [int];
  logic [15:0] expRam [int];
  int loW, topW, fsW, ovfExp, lastWr, stopHits;
  bit lastCommitted;
  int seed;

  always #5 clk = ~clk;

  rxring_writer u_rxring_writer (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inData(inData), .inLast(inLast),
    .inErr(inErr), .discardBad(discardBad), .lowerPage(lowerPage),
    .upperPage(upperPage), .stopPtr(stopPtr), .memWe(memWe), .memAddr(memAddr),
    .memData(memData), .ovfCount(ovfCount)
  );

  // Model RAM plus stop-word and last-write monitor
  always @(posedge clk) begin
    if (memWe) begin
      ram[int'(memAddr[14:1])] = memData;
      lastWr = int'(memAddr[14:1]);
      if (memAddr[14:1] == stopPtr[14:1]) stopHits++;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] rd(input int w);
    return ram.exists(w) ? ram[w] : 16'h0000;
  endfunction
  function automatic logic [15:0] erd(input int w);
    return expRam.exists(w) ? expRam[w] : 16'h0000;
  endfunction
  function automatic int stepW(input int p);
    return (p == topW) ? loW : p + 1;
  endfunction
  function automatic int prevW(input int p);
    return (p == loW) ? topW : p - 1;
  endfunction

  task automatic compareRing(input string req);
    int bad = 0, badW = 0;
    for (int w = loW; w <= topW; w++)
      if (rd(w) !== erd(w)) begin
        if (bad == 0) badW = w;
        bad++;
      end
    check(bad == 0, req, int'(rd(badW)), int'(erd(badW)));
  endtask

  task automatic doReset(input int lo, input int up, input int stopB);
    rstN = 1'b0;
    lowerPage = 7'(lo); upperPage = 7'(up); stopPtr = 15'(stopB);
    ram.delete(); expRam.delete();
    loW = lo << 7; topW = (up << 7) | 127;
    fsW = loW; ovfExp = 0; lastWr = -1;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  task automatic consume();
    stopPtr = 15'(prevW(fsW) << 1);
  endtask

  task automatic runFrame(input int len, input bit err, input string req);
    logic [7:0] bytes [$];
    int s = fsW, h1, h2, h3, d, stopW;
    bit drop = 0;
    for (int i = 0; i < len; i++) bytes.push_back(8'($urandom));
    // expected result from the requirements
    stopW = int'(stopPtr[14:1]);
    h1 = stepW(s); h2 = stepW(h1); h3 = stepW(h2); d = stepW(h3);
    if (s == stopW || h1 == stopW || h2 == stopW || h3 == stopW) drop = 1; // R8 header
    for (int i = 0; i < len && !drop; i += 2) begin
      if (d == stopW) drop = 1;  // R8 data
      else begin
        expRam[d] = (i + 1 < len) ? {bytes[i+1], bytes[i]} : {8'h00, bytes[i]};
        d = stepW(d);
      end
    end
    lastCommitted = 0;
    if (drop) ovfExp++;
    else if (!(err && discardBad)) begin
      expRam[h1] = err ? 16'h0001 : 16'h2000;
      expRam[h2] = 16'(d << 1);
      expRam[h3] = 16'(len);
      if (d != stopW) expRam[d] = 16'h0000;  // R10
      expRam[s] = 16'h0008;
      fsW = d;
      lastCommitted = 1;
    end
    // drive
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      inValid = 1'b1; inData = bytes[i];
      inLast = (i == len - 1); inErr = err && (i == len - 1);
    end
    @(negedge clk);
    inValid = 1'b0; inLast = 1'b0; inErr = 1'b0;
    repeat (8) @(negedge clk);
    check(ovfCount == 16'(ovfExp), {req, " overflow count"}, int'(ovfCount), ovfExp);
    compareRing({req, " ring contents"});
    if (lastCommitted) check(lastWr == s, "R3 event written last", lastWr, s);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int saved;
    seed = $urandom(32'h5eed1234);
    stopHits = 0;
    doReset(1, 3, 'h3FE);
    check(memWe == 1'b0, "R1 no write after reset", int'(memWe), 0);
    check(ovfCount == 16'h0, "R1 ovfCount after reset", int'(ovfCount), 0);

    runFrame(4, 0, "R1 R2 first frame");
    check(rd(loW) == 16'h0008, "R1 event at lower limit", int'(rd(loW)), 8);
    check(rd(loW + 2) == 16'((loW + 6) << 1), "R2 next pointer",
          int'(rd(loW + 2)), (loW + 6) << 1);
    check(rd(loW + 1) == 16'h2000, "R4 good status", int'(rd(loW + 1)), 'h2000);
    consume();
    saved = fsW;
    runFrame(1, 0, "R5 single byte");
    check(rd(saved + 4) == erd(saved + 4) && rd(saved + 4) < 16'h0100,
          "R5 padded high byte", int'(rd(saved + 4)), int'(erd(saved + 4)));
    check(fsW == saved + 5, "R5 next start word", fsW, saved + 5);
    consume();
    runFrame(7, 0, "R5 odd length");
    consume();
    runFrame(2, 0, "R2 R10 clear next");

    consume();
    discardBad = 1'b0;
    saved = fsW;
    runFrame(10, 1, "R4 kept errored");
    check(rd(saved + 1) == 16'h0001, "R4 errored status", int'(rd(saved + 1)), 1);
    consume();
    discardBad = 1'b1;
    saved = fsW;
    runFrame(10, 1, "R9 discarded");
    check(rd(saved) != 16'h0008, "R9 no event", int'(rd(saved)), 0);
    runFrame(6, 0, "R9 space reused");
    check(rd(saved) == 16'h0008, "R9 reuse start", int'(rd(saved)), 8);

    consume();
    for (int i = 0; i < 20; i++) runFrame(40, 0, "R8 R11 no consumption");
    check(ovfExp > 0 && ovfCount == 16'(ovfExp), "R8 overflow seen", int'(ovfCount), ovfExp);

    for (int i = 0; i < 70; i++) begin
      if ($urandom_range(0, 9) < 8) consume();
      discardBad = $urandom_range(0, 1) == 1;
      runFrame(int'($urandom_range(1, 48)), $urandom_range(0, 4) == 0, "R2 R6 R8 random");
    end

    // one-page ring: wrap and stop collide on the top word
    doReset('h10, 'h10, 'h10FE);
    runFrame(100, 0, "R6 wrap setup");
    runFrame(100, 0, "R6 wrap setup");
    saved = fsW;
    runFrame(100, 0, "R6 R8 wrap meets stop");
    check(ovfCount == 16'd1 && fsW == saved, "R8 dropped at wrap", int'(ovfCount), 1);
    consume();
    runFrame(100, 0, "R6 wrapped frame");
    check(rd(saved) == 16'h0008 && fsW < saved, "R6 wrapped commit", fsW, saved);

    check(stopHits == 0, "R7 stop word never written", stopHits, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule